// File: doc/BRIEF.md
# Mailbox Slave Event Interrupt Flags

This block is the slave-side event register of a host-to-slave mailbox. It holds three sticky status flags. The first records that the host has fetched the status code from the shared status/control register. The second records that the host has deposited a control code in that register. The third records that the host has begun a transfer, which the block detects as a rising edge on the host busy bit. The flags exist only on the slave side, and the host cannot see or change them. The block reports them to the slave processor on a single interrupt request line.

Slave firmware reads the flag register to find which event occurred. It then writes 0 to the bits it has handled. A flag drops only when the slave has first read that bit as 1 and then writes 0 to it. A blind write therefore cannot discard an event the firmware has not yet seen. The interrupt for a flag is gated by a shared mailbox interrupt enable and by that flag's own enable. The gated flags are ORed together and the result is registered.

Top module: `mboxIrqFlags`

## Requirements
- R1: A cycle with `hostStatRd` high sets the status-fetched flag (read bit 2) at the next clock edge.
- R2: A cycle with `hostCtlWr` high sets the control-deposited flag (read bit 1) at the next clock edge.
- R3: The transfer-start flag (read bit 0) sets only when `hostBusy` goes from 0 to 1 between two clock edges after reset. A busy level that stays high sets nothing more. A busy bit that is already 1 when reset is released produces no event.
- R4: A slave write clears a flag only where the written bit is 0 and an earlier slave read returned that flag as 1. A 0 written without such a read leaves the flag at 1.
- R5: Writing 1 to a flag bit never changes that flag.
- R6: When a set event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R7: `slvIrq` equals, one cycle late, `bufIrqEn` ANDed with the OR over the three flags of (flag AND its `flagIrqEn` bit). Bit 2, 1 and 0 of `flagIrqEn` pair with the flags of the same read position.
- R8: After reset, all flags read 0 and `slvIrq` is 0.
- R9: `slvRdData` shows the flags in bits 2 (status fetched), 1 (control deposited) and 0 (transfer start). Every other bit reads 0.
- R10: A clearing write uses up the read that armed it. After the flag sets again, a new read as 1 is needed before a 0 write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostStatRd | input | 1 | Host read strobe of the shared status/control register |
| hostCtlWr | input | 1 | Host write strobe of the shared status/control register |
| hostBusy | input | 1 | Host busy bit from the mailbox flag register |
| slvRdEn | input | 1 | Slave read of the flag register this cycle |
| slvWrEn | input | 1 | Slave write of the flag register this cycle |
| slvWrData | input | DATA_W | Slave write data; bits 2..0 address the flags |
| bufIrqEn | input | 1 | Shared mailbox interrupt enable |
| flagIrqEn | input | 3 | Per-flag interrupt enables (bit order as read data) |
| slvRdData | output | DATA_W | Flag register read value |
| slvIrq | output | 1 | Registered interrupt request to the slave |

## Verification
The assertions check on every cycle that each host event sets its flag, that a flag never drops without a slave write, that a write of 1 leaves a flag alone, that the reserved read bits stay 0, and that the interrupt follows the gated flags one cycle late. The read-before-clear rule needs a history of earlier reads. The bench shows it with scenarios: a clear with no prior read, a clear after a read, and a second clear after the arm has been used up. The same-cycle race between setting and clearing is also shown by scenario. Busy handling at reset release and under a held busy level is shown by scenario as well.

// File: rtl/mboxIrqPkg.sv
package mboxIrqPkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_XFER  = 0;  // transfer start (busy rising edge)
  localparam int FLG_CTL   = 1;  // control code deposited by host
  localparam int FLG_STAT  = 2;  // status code fetched by host

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setFlag;
    logic [NUM_FLAGS-1:0] clrFlag;
  } flagStrobes_t;
endpackage

// File: rtl/mboxIrqCtrl.sv
module mboxIrqCtrl
  import mboxIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostStatRd,
  input  logic                 hostCtlWr,
  input  logic                 hostBusy,
  input  logic                 slvRdEn,
  input  logic                 slvWrEn,
  input  logic [DATA_W-1:0]    slvWrData,
  input  logic [NUM_FLAGS-1:0] flagQ,
  output flagStrobes_t         strobes
);
  logic                 busyPrev;
  logic                 edgeOk;     // one clock seen since reset release
  logic                 busyRise;
  logic [NUM_FLAGS-1:0] armQ;       // flag was read as 1 by the slave
  logic [NUM_FLAGS-1:0] clrHit;

  // Busy edge detector; the first sample after reset only primes busyPrev
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyPrev <= 1'b0;
      edgeOk   <= 1'b0;
    end else begin
      busyPrev <= hostBusy;
      edgeOk   <= 1'b1;
    end
  end

  assign busyRise = edgeOk & hostBusy & ~busyPrev;

  // A 0 written onto an armed flag is a valid clear
  assign clrHit = slvWrEn ? (armQ & ~slvWrData[NUM_FLAGS-1:0]) : '0;

  always_comb begin
    strobes                   = '0;
    strobes.setFlag[FLG_STAT] = hostStatRd;
    strobes.setFlag[FLG_CTL]  = hostCtlWr;
    strobes.setFlag[FLG_XFER] = busyRise;
    strobes.clrFlag           = clrHit;
  end

  // Per-flag arm bits: set by a read that sees 1, consumed by the clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gArm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        armQ[i] <= 1'b0;
      else if (clrHit[i])
        armQ[i] <= 1'b0;
      else if (slvRdEn && flagQ[i])
        armQ[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/mboxIrqData.sv
module mboxIrqData
  import mboxIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         strobes,
  input  logic                 bufIrqEn,
  input  logic [NUM_FLAGS-1:0] flagIrqEn,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [DATA_W-1:0]    slvRdData,
  output logic                 slvIrq
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] gated;

  // Flag storage: a set event takes priority over a clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        flagQ[i] <= 1'b0;
      else if (strobes.setFlag[i])
        flagQ[i] <= 1'b1;
      else if (strobes.clrFlag[i])
        flagQ[i] <= 1'b0;
    end
  end

  assign gated = flagQ & flagIrqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      slvIrq <= 1'b0;
    else
      slvIrq <= bufIrqEn & (|gated);
  end

  assign slvRdData = {{PAD_W{1'b0}}, flagQ};
endmodule

// File: rtl/mboxIrqFlags.sv
module mboxIrqFlags
  import mboxIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostStatRd,
  input  logic                 hostCtlWr,
  input  logic                 hostBusy,
  input  logic                 slvRdEn,
  input  logic                 slvWrEn,
  input  logic [DATA_W-1:0]    slvWrData,
  input  logic                 bufIrqEn,
  input  logic [NUM_FLAGS-1:0] flagIrqEn,
  output logic [DATA_W-1:0]    slvRdData,
  output logic                 slvIrq
);
  flagStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] flagQ;

  mboxIrqCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostStatRd(hostStatRd),
    .hostCtlWr (hostCtlWr),
    .hostBusy  (hostBusy),
    .slvRdEn   (slvRdEn),
    .slvWrEn   (slvWrEn),
    .slvWrData (slvWrData),
    .flagQ     (flagQ),
    .strobes   (strobes)
  );

  mboxIrqData #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bufIrqEn (bufIrqEn),
    .flagIrqEn(flagIrqEn),
    .flagQ    (flagQ),
    .slvRdData(slvRdData),
    .slvIrq   (slvIrq)
  );
endmodule

// File: rtl/mboxIrqChecker.sv
module mboxIrqChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostStatRd,
  input logic              hostCtlWr,
  input logic              hostBusy,
  input logic              slvRdEn,
  input logic              slvWrEn,
  input logic [DATA_W-1:0] slvWrData,
  input logic              bufIrqEn,
  input logic [2:0]        flagIrqEn,
  input logic [DATA_W-1:0] slvRdData,
  input logic              slvIrq
);
  logic pastOk;
  logic busyLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastOk   <= 1'b0;
      busyLast <= 1'b0;
    end else begin
      pastOk   <= 1'b1;
      busyLast <= hostBusy;
    end
  end

  p_stat_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostStatRd |=> slvRdData[2]);

  p_ctl_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostCtlWr |=> slvRdData[1]);

  p_busy_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && hostBusy && !busyLast) |=> slvRdData[0]);

  for (genvar i = 0; i < 3; i++) begin : gBit
    // R4: a flag only drops through a slave write
    p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (slvRdData[i] && !slvWrEn) |=> slvRdData[i]);
    // R5: writing 1 keeps the flag
    p_write_one_r5: assert property (@(posedge clk) disable iff (!rstN)
      (slvRdData[i] && slvWrEn && slvWrData[i]) |=> slvRdData[i]);
  end

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (slvIrq == $past(bufIrqEn && ((slvRdData[2:0] & flagIrqEn) != 3'b000))));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    slvRdData[DATA_W-1:3] == '0);
endmodule

bind mboxIrqFlags mboxIrqChecker #(.DATA_W(DATA_W)) uChecker (.*);

// File: tb/test_mboxIrqFlags.sv
`timescale 1ns/1ps
module test_mboxIrqFlags;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostStatRd = 1'b0;
  logic              hostCtlWr = 1'b0;
  logic              hostBusy = 1'b0;
  logic              slvRdEn = 1'b0;
  logic              slvWrEn = 1'b0;
  logic [DATA_W-1:0] slvWrData = '0;
  logic              bufIrqEn = 1'b0;
  logic [2:0]        flagIrqEn = 3'b000;
  logic [DATA_W-1:0] slvRdData;
  logic              slvIrq;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mboxIrqFlags #(.DATA_W(DATA_W)) i_mboxIrqFlags (.*);

  // Behavioural reference
  bit [2:0] mFlag, mArm;
  bit       mIrq, mBusyPrev, mEdgeOk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlag = '0; mArm = '0; mIrq = 0; mBusyPrev = 0; mEdgeOk = 0;
    end else begin
      bit [2:0] ev;
      bit [2:0] nf, na;
      ev[2] = hostStatRd;
      ev[1] = hostCtlWr;
      ev[0] = mEdgeOk && hostBusy && !mBusyPrev;
      mIrq = bufIrqEn && ((mFlag & flagIrqEn) != 0);
      for (int i = 0; i < 3; i++) begin
        bit kill;
        kill = slvWrEn && mArm[i] && !slvWrData[i];
        nf[i] = ev[i] ? 1'b1 : (kill ? 1'b0 : mFlag[i]);
        na[i] = kill ? 1'b0 : (mArm[i] || (slvRdEn && mFlag[i]));
      end
      mFlag = nf; mArm = na;
      mBusyPrev = hostBusy; mEdgeOk = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle compare against the model (R9 layout, R7 interrupt)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(slvRdData == {5'b0, mFlag}, "R9 model readback", slvRdData, {5'b0, mFlag});
      check(slvIrq == mIrq, "R7 model irq", slvIrq, mIrq);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic sample(); @(negedge clk); endtask

  task automatic slvRead();
    slvRdEn = 1; step(); slvRdEn = 0;
  endtask
  task automatic slvWrite(input logic [7:0] d);
    slvWrEn = 1; slvWrData = d; step(); slvWrEn = 0; slvWrData = '0;
  endtask

  initial begin
    #200000;
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    hostBusy = 1;                       // busy already high across reset
    repeat (3) @(posedge clk);
    #1; sample();
    check(slvRdData == 0, "R8 reset flags", slvRdData, 0);
    check(slvIrq == 0, "R8 reset irq", slvIrq, 0);
    step(); rstN = 1;
    repeat (3) step();
    sample();
    check(slvRdData[0] == 0, "R3 busy high at reset", slvRdData[0], 0);

    // R3: true rising edge
    step(); hostBusy = 0; step(); hostBusy = 1; step(); sample();
    check(slvRdData[0] == 1, "R3 busy rise", slvRdData[0], 1);
    step(); slvRead(); slvWrite(8'h00); repeat (3) step(); sample();
    check(slvRdData[0] == 0, "R3 held level no reset", slvRdData[0], 0);
    step(); hostBusy = 0;

    // R1 then R4/R5
    step(); hostStatRd = 1; step(); hostStatRd = 0; sample();
    check(slvRdData == 8'h04, "R1 status fetched", slvRdData, 8'h04);
    step(); slvWrite(8'h00); sample();
    check(slvRdData[2] == 1, "R4 unarmed clear ignored", slvRdData[2], 1);
    step(); slvRead(); slvWrite(8'hFF); sample();
    check(slvRdData[2] == 1, "R5 write one no effect", slvRdData[2], 1);
    step(); slvWrite(8'hFB); sample();
    check(slvRdData[2] == 0, "R4 armed clear", slvRdData[2], 0);

    // R2 and R7 gating
    step(); hostCtlWr = 1; step(); hostCtlWr = 0; sample();
    check(slvRdData == 8'h02, "R2 control deposited", slvRdData, 8'h02);
    step(); flagIrqEn = 3'b010; bufIrqEn = 0; step(); step(); sample();
    check(slvIrq == 0, "R7 master enable off", slvIrq, 0);
    step(); bufIrqEn = 1; step(); sample();
    check(slvIrq == 1, "R7 both enables", slvIrq, 1);
    step(); flagIrqEn = 3'b101; step(); sample();
    check(slvIrq == 0, "R7 other flag enables", slvIrq, 0);

    // R6: set beats clear in the same cycle
    step(); slvRead();
    slvWrEn = 1; slvWrData = 8'h00; hostCtlWr = 1; step();
    slvWrEn = 0; hostCtlWr = 0; sample();
    check(slvRdData[1] == 1, "R6 set wins", slvRdData[1], 1);
    // R10: arm was consumed
    step(); slvWrite(8'h00); sample();
    check(slvRdData[1] == 1, "R10 arm consumed", slvRdData[1], 1);
    step(); slvRead(); slvWrite(8'h00); sample();
    check(slvRdData[1] == 0, "R10 rearmed clear", slvRdData[1], 0);

    // R9 full layout, R7 OR of flags
    step(); hostStatRd = 1; hostCtlWr = 1; hostBusy = 1; step();
    hostStatRd = 0; hostCtlWr = 0; sample();
    check(slvRdData == 8'h07, "R9 all flags layout", slvRdData, 8'h07);
    step(); flagIrqEn = 3'b001; step(); sample();
    check(slvIrq == 1, "R7 xfer enable", slvIrq, 1);
    step(); hostBusy = 0;
    repeat (4) step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule